// File: doc/BRIEF.md
# Instance-Array Memory-Mapped Bus Multiplexer

This block fans one memory-mapped master port out to an array of identical slave instances. Each slave answers to a fixed number of word addresses that need not be a power of two. The mux rounds that count up to the next power of two and uses the result as the stride between instances. Instance `k` therefore owns the word addresses `k*STRIDE` to `k*STRIDE + STRIDE - 1`, and the total span is the instance count times the stride.

Because the stride is a power of two, decoding needs no comparator chain. The low `log2(STRIDE)` bits of the master word address become the local address, which goes to all slaves on a shared bus. The bits above them select the instance. Read and write strobes reach only the selected slave. The selected slave's read data is returned one clock after the read strobe. An index at or above the instance count addresses no slave. With a single instance the mux is a plain pass-through with no index bits.

The instance count and the per-instance address count are parameters. The system level overrides them; the defaults describe a five-instance array of five-word slaves.

Top module: `mmx_inst_array`

## Requirements
- R1: `s_addr` equals the low `LOC_W` bits of `m_addr`, where `LOC_W = ceil(log2(SLV_ADDRS))` (minimum 1), and `s_wdata` equals `m_wdata`. With the defaults, `LOC_W` is 3, so the stride is 8.
- R2: While `m_wr` is high with an in-range index, exactly one bit of `s_wr` is high: bit `m_addr >> LOC_W`. All other bits are low.
- R3: While `m_rd` is high with an in-range index, exactly one bit of `s_rd` is high: bit `m_addr >> LOC_W`. All other bits are low.
- R4: In the cycle after an in-range read, `m_rdata` carries the read data that the selected instance registered on that read.
- R5: An access whose index (`m_addr >> LOC_W`) is `NUM_INST` or more asserts no bit of `s_wr` or `s_rd`. It therefore changes no slave's contents.
- R6: In the cycle after a read whose index is out of range, `m_rdata` is zero.
- R7: Instance `k` occupies master word addresses `k*2**LOC_W` to `k*2**LOC_W + 2**LOC_W - 1`. With the defaults, address 8 reaches instance 1 at local address 0, and address 39 reaches instance 4 at local address 7.
- R8: With `NUM_INST = 1`, `m_addr` is `LOC_W` bits wide and passes straight to `s_addr`. `s_wr` and `s_rd` follow `m_wr` and `m_rd`, and the read data comes back one cycle later.
- R9: After a synchronous active-low reset, and in any cycle that does not follow an in-range read, `m_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_addr | input | ADDR_W | Master word address |
| m_wr | input | 1 | Master write strobe |
| m_rd | input | 1 | Master read strobe |
| m_wdata | input | DATA_W | Master write data |
| m_rdata | output | DATA_W | Master read data, one cycle after `m_rd` |
| s_addr | output | LOC_W | Local address shared by all instances |
| s_wdata | output | DATA_W | Write data shared by all instances |
| s_wr | output | NUM_INST | Per-instance write strobes |
| s_rd | output | NUM_INST | Per-instance read strobes |
| s_rdata | input | NUM_INST*DATA_W | Concatenated instance read data, instance 0 in the low bits |

## Verification
The bench drives addresses that sit on both edges of each stride window. A design that divided by the slave size instead of slicing at the power-of-two stride would send address 8 to instance 1 at the wrong local address, or would mis-route address 39. Addresses 40 to 63 decode to indices 5 to 7, which no instance uses. A design without the range check would strobe a non-existent lane, or let the index wrap onto a real one, and would return stale data instead of zero. Back-to-back reads of different instances show whether the returned data follows the registered index or the live address. A separate single-instance build checks that the pass-through case still works with no index bits.

// File: rtl/mmx_pkg.sv
// Package: shared helpers for the instance-array mux.
// Assumes: callers pass positive counts.
package mmx_pkg;

    // Bits needed to index v items; never less than one.
    function automatic int clog2_min1(input int v);
        int r;
        r = 0;
        while ((1 << r) < v) r++;
        return (r < 1) ? 1 : r;
    endfunction

    // Index bits on the master address; zero for a single instance.
    function automatic int idx_bits(input int n);
        int r;
        r = 0;
        while ((1 << r) < n) r++;
        return r;
    endfunction

endpackage

// File: rtl/mmx_addr_split.sv
// Module: mmx_addr_split
// Splits the master word address into a local address (low LOC_W bits)
// and an instance index (the bits above them). It flags whether the
// index names an existing instance.
// Assumes: ADDR_W == LOC_W + index bits; with a single instance there
// are no index bits, so the index is 0 and always in range.
module mmx_addr_split #(
    parameter int NUM_INST = 5,
    parameter int LOC_W    = 3,
    parameter int IDX_W    = 3,
    parameter int ADDR_W   = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [LOC_W-1:0]  loc,
    output logic [IDX_W-1:0]  idx,
    output logic              in_rng
);
    // Local address is always the low slice of the master address.
    assign loc = addr[LOC_W-1:0];

    generate
        if (NUM_INST == 1) begin : g_single
            // Single instance: no index field on the master address.
            assign idx    = '0;
            assign in_rng = 1'b1;
        end else begin : g_multi
            localparam logic [IDX_W:0] LIMIT = NUM_INST[IDX_W:0];
            // Index is the slice above the local bits.
            assign idx    = addr[ADDR_W-1:LOC_W];
            // An index must lie below the instance count to be served.
            assign in_rng = ({1'b0, idx} < LIMIT);
        end
    endgenerate
endmodule

// File: rtl/mmx_strobe_steer.sv
// Module: mmx_strobe_steer
// Decodes the instance index into per-lane write and read strobes.
// Only the selected lane can see a strobe; out-of-range accesses
// strobe nothing.
// Assumes: in_rng comes from the address split of the same cycle.
module mmx_strobe_steer #(
    parameter int NUM_INST = 5,
    parameter int IDX_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic                rd,
    input  logic [IDX_W-1:0]    idx,
    input  logic                in_rng,
    output logic [NUM_INST-1:0] wr_lane,
    output logic [NUM_INST-1:0] rd_lane
);
    genvar gi;
    generate
        for (gi = 0; gi < NUM_INST; gi++) begin : g_lane
            localparam logic [IDX_W-1:0] LANE = IDX_W'(gi);
            // Lane gi is picked when the index names it and lies in range.
            logic hit;
            assign hit         = in_rng && (idx == LANE);
            assign wr_lane[gi] = wr && hit;
            assign rd_lane[gi] = rd && hit;
        end
    endgenerate

    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_lane)); // R2
    AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_lane)); // R3
    AST_OOR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_rng |-> (wr_lane == '0 && rd_lane == '0)); // R5
endmodule

// File: rtl/mmx_rdata_ret.sv
// Module: mmx_rdata_ret
// Registers the index and hit flag of each read, then uses them one
// cycle later to pick the returned word from the lane that was read.
// Returns zero in every cycle that does not follow an in-range read.
// Assumes: every slave has a fixed read latency of one cycle.
module mmx_rdata_ret #(
    parameter int NUM_INST = 5,
    parameter int IDX_W    = 3,
    parameter int DATA_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd,
    input  logic                       in_rng,
    input  logic [IDX_W-1:0]           idx,
    input  logic [NUM_INST*DATA_W-1:0] lane_rdata,
    output logic [DATA_W-1:0]          rdata
);
    logic             hit_q;
    logic [IDX_W-1:0] idx_q;

    // Capture which lane a read went to, for the return cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            idx_q <= '0;
        end else begin
            hit_q <= rd && in_rng;
            if (rd) idx_q <= idx;
        end
    end

    // AND-OR select of the lane captured on the previous read.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_INST; i++) begin
            if (hit_q && (idx_q == IDX_W'(i)))
                rdata = rdata | lane_rdata[i*DATA_W +: DATA_W];
        end
    end

    AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !in_rng) |=> (rdata == '0)); // R6
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (rdata == '0)); // R9
endmodule

// File: rtl/mmx_inst_array.sv
// Module: mmx_inst_array (top)
// Connects one memory-mapped master to NUM_INST identical slaves,
// each owning a window of 2**LOC_W words at a power-of-two stride.
// Address bus and write data are shared; strobes are per lane; read
// data returns one cycle after the read strobe.
// Assumes: NUM_INST >= 1, SLV_ADDRS >= 1, slaves have a one-cycle
// read latency, and reads and writes are not issued together.
module mmx_inst_array #(
    parameter  int NUM_INST  = 5,
    parameter  int SLV_ADDRS = 5,
    parameter  int DATA_W    = 32,
    localparam int LOC_W     = mmx_pkg::clog2_min1(SLV_ADDRS),
    localparam int IDX_B     = mmx_pkg::idx_bits(NUM_INST),
    localparam int IDX_W     = (IDX_B < 1) ? 1 : IDX_B,
    localparam int ADDR_W    = LOC_W + IDX_B
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          m_addr,
    input  logic                       m_wr,
    input  logic                       m_rd,
    input  logic [DATA_W-1:0]          m_wdata,
    output logic [DATA_W-1:0]          m_rdata,
    output logic [LOC_W-1:0]           s_addr,
    output logic [DATA_W-1:0]          s_wdata,
    output logic [NUM_INST-1:0]        s_wr,
    output logic [NUM_INST-1:0]        s_rd,
    input  logic [NUM_INST*DATA_W-1:0] s_rdata
);
    logic [IDX_W-1:0] idx;
    logic             in_rng;

    mmx_addr_split #(
        .NUM_INST(NUM_INST), .LOC_W(LOC_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
    ) u_split (
        .addr(m_addr), .loc(s_addr), .idx(idx), .in_rng(in_rng)
    );

    mmx_strobe_steer #(
        .NUM_INST(NUM_INST), .IDX_W(IDX_W)
    ) u_steer (
        .clk(clk), .rst_n(rst_n), .wr(m_wr), .rd(m_rd), .idx(idx),
        .in_rng(in_rng), .wr_lane(s_wr), .rd_lane(s_rd)
    );

    mmx_rdata_ret #(
        .NUM_INST(NUM_INST), .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) u_ret (
        .clk(clk), .rst_n(rst_n), .rd(m_rd), .in_rng(in_rng), .idx(idx),
        .lane_rdata(s_rdata), .rdata(m_rdata)
    );

    // Write data goes to every lane; only the strobe differs.
    assign s_wdata = m_wdata;

    AST_LOC_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
        s_addr == m_addr[LOC_W-1:0]); // R1
    AST_WR_REACH: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wr && in_rng) |-> (s_wr != '0)); // R2
    AST_RD_REACH: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rd && in_rng) |-> (s_rd != '0)); // R3
    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_wr && !m_rd) |-> (s_wr == '0 && s_rd == '0)); // R5
endmodule

// File: tb/sim_mmx_inst_array.sv
// Bench for mmx_inst_array: a vector table walked by one loop, then
// directed tests for reset, idle, back-to-back and single-instance cases.
module sim_mmx_inst_array;
    localparam int CLK_P = 10;
    localparam int N     = 5;
    localparam int DW    = 32;
    localparam int NV    = 12;

    // Master addresses exercised; index 5..7 (addr >= 40) is out of range.
    localparam logic [5:0] VA [NV] = '{6'd0, 6'd4, 6'd7, 6'd8, 6'd13, 6'd16,
                                       6'd31, 6'd33, 6'd39, 6'd40, 6'd47, 6'd63};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    // DUT u0: five instances of five words.
    logic [5:0]    m_addr = '0;
    logic          m_wr = 1'b0, m_rd = 1'b0;
    logic [DW-1:0] m_wdata = '0, m_rdata;
    logic [2:0]    s_addr;
    logic [DW-1:0] s_wdata;
    logic [N-1:0]  s_wr, s_rd;
    logic [N*DW-1:0] s_rdata;

    mmx_inst_array #(.NUM_INST(N), .SLV_ADDRS(5), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_wr(m_wr), .m_rd(m_rd),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .s_addr(s_addr),
        .s_wdata(s_wdata), .s_wr(s_wr), .s_rd(s_rd), .s_rdata(s_rdata)
    );

    // Behavioural slaves: 8-word stores with one-cycle registered reads.
    logic [DW-1:0] smem [N][8];
    logic [DW-1:0] srd_q [N];
    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (s_wr[i]) smem[i][s_addr] <= s_wdata;
            if (s_rd[i]) srd_q[i] <= smem[i][s_addr];
        end
    end
    for (genvar g = 0; g < N; g++) begin : g_sl
        assign s_rdata[g*DW +: DW] = srd_q[g];
    end

    // DUT u1: single instance, pass-through.
    logic [2:0]    p_addr = '0;
    logic          p_wr = 1'b0, p_rd = 1'b0;
    logic [DW-1:0] p_wdata = '0, p_rdata, p_swdata, p_srdq;
    logic [2:0]    p_saddr;
    logic [0:0]    p_swr, p_srd;
    logic [DW-1:0] pmem [8];

    mmx_inst_array #(.NUM_INST(1), .SLV_ADDRS(5), .DATA_W(DW)) u1 (
        .clk(clk), .rst_n(rst_n), .m_addr(p_addr), .m_wr(p_wr), .m_rd(p_rd),
        .m_wdata(p_wdata), .m_rdata(p_rdata), .s_addr(p_saddr),
        .s_wdata(p_swdata), .s_wr(p_swr), .s_rd(p_srd), .s_rdata(p_srdq)
    );
    always @(posedge clk) begin
        if (p_swr[0]) pmem[p_saddr] <= p_swdata;
        if (p_srd[0]) p_srdq <= pmem[p_saddr];
    end

    // Reference contents, indexed by master address.
    logic [DW-1:0] ref_mem [64];

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit in_rng(input logic [5:0] a);
        return (a >> 3) < N;
    endfunction

    function automatic logic [N-1:0] lane_of(input logic [5:0] a);
        return in_rng(a) ? (N'(1) << (a >> 3)) : '0;
    endfunction

    task automatic do_write(input logic [5:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        m_addr = a; m_wdata = d; m_wr = 1'b1;
        #1;
        check(s_wr == lane_of(a), "R2/R5/R7 wr steer", DW'(s_wr), DW'(lane_of(a)));
        check(s_addr == a[2:0] && s_wdata == d, "R1 local addr", DW'(s_addr), DW'(a[2:0]));
        if (in_rng(a)) ref_mem[a] = d;
        @(negedge clk);
        m_wr = 1'b0;
    endtask

    task automatic do_read(input logic [5:0] a);
        logic [DW-1:0] exp;
        exp = in_rng(a) ? ref_mem[a] : '0;
        @(negedge clk);
        m_addr = a; m_rd = 1'b1;
        #1;
        check(s_rd == lane_of(a), "R3/R5 rd steer", DW'(s_rd), DW'(lane_of(a)));
        @(negedge clk);
        m_rd = 1'b0;
        check(m_rdata == exp, in_rng(a) ? "R4 rdata" : "R6 oor rdata", m_rdata, exp);
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state, no strobes and zero read data.
        check(m_rdata == '0, "R9 reset rdata", m_rdata, '0);
        check(s_wr == '0 && s_rd == '0, "R5 idle strobes", DW'({s_wr, s_rd}), '0);

        // Vector walk: write each address, then read each back.
        for (int v = 0; v < NV; v++) do_write(VA[v], 32'hA500_0000 | DW'(v * 7 + 1));
        for (int v = 0; v < NV; v++) do_read(VA[v]);

        // R5: the out-of-range writes left every slave untouched.
        do_write(6'd40, 32'hDEAD_0001);
        do_read(6'd0);
        do_read(6'd8);

        // R4: back-to-back reads of different instances.
        @(negedge clk);
        m_addr = 6'd13; m_rd = 1'b1;
        @(negedge clk);
        m_addr = 6'd33;
        check(m_rdata == ref_mem[13], "R4 b2b first", m_rdata, ref_mem[13]);
        @(negedge clk);
        m_rd = 1'b0;
        check(m_rdata == ref_mem[33], "R4 b2b second", m_rdata, ref_mem[33]);
        @(negedge clk);
        check(m_rdata == '0, "R9 idle rdata", m_rdata, '0);

        // R8: single-instance pass-through.
        @(negedge clk);
        p_addr = 3'd6; p_wdata = 32'h1234_5678; p_wr = 1'b1;
        #1;
        check(p_swr == 1'b1 && p_saddr == 3'd6, "R8 pass wr", DW'({p_swr, p_saddr}), DW'({1'b1, 3'd6}));
        @(negedge clk);
        p_wr = 1'b0; p_rd = 1'b1;
        #1;
        check(p_srd == 1'b1, "R8 pass rd", DW'(p_srd), 1);
        @(negedge clk);
        p_rd = 1'b0;
        check(p_rdata == 32'h1234_5678, "R8 pass rdata", p_rdata, 32'h1234_5678);

        // R9: synchronous reset clears a pending return.
        @(negedge clk);
        m_addr = 6'd0; m_rd = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        m_rd = 1'b0;
        check(m_rdata == '0, "R9 rdata in reset", m_rdata, '0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule